// File: doc/BRIEF.md
# Display Sync and Beep Timer

This block is the timing generator of a character display terminal. It advances on a 1 MHz enable tick and produces three outputs: a horizontal sync pulse train, a vertical sync pulse whose rate matches the mains frequency, and an audio alarm level. The alarm is timed in whole display frames, so its length follows the selected mains rate.

A rate select input chooses between 50 Hz and 60 Hz frames. The new rate takes effect at the next frame boundary, so a frame is never cut short. A rising edge on the beep enable input arms the alarm. The alarm sounds from the start of the next frame for a fixed number of frames. With the default 15 frames this gives about 300 ms at 50 Hz and about 250 ms at 60 Hz. A second request while the alarm is sounding starts the frame count again.

Top module: `disp_sync_beep`

## Requirements
- R1: While reset is active and in the first cycle after it, hsync and vsync are 1 and beep_out is 0.
- R2: The line counter advances only in cycles where tick_1us is 1. hsync does not change after a cycle without a tick.
- R3: A line lasts LINE_TICKS ticks (default 63). hsync is 1 for the first HS_TICKS ticks of each line (default 12) and 0 for the rest.
- R4: A frame lasts FRAME_50 ticks (default 20000) when the latched rate is 50 Hz, and FRAME_60 ticks (default 16667) when it is 60 Hz. vsync is 1 for the first VS_TICKS ticks of each frame (default 192). vsync does not change after a cycle without a tick.
- R5: rate_50hz = 1 selects 50 Hz and 0 selects 60 Hz. The value is sampled only at the frame boundary (and at reset), so the frame in progress keeps its length.
- R6: beep_out stays 0 when no rising edge of beep_en has occurred.
- R7: After a rising edge of beep_en, beep_out goes to 1 in the same cycle that vsync rises at the next frame start. It stays 1 for exactly BEEP_FRAMES frames (default 15) and falls in the cycle that vsync rises.
- R8: A rising edge of beep_en while beep_out is 1 reloads the count at the next frame boundary. beep_out then stays 1 for BEEP_FRAMES more frames from that boundary.
- R9: Only a 0-to-1 change of beep_en is a request. Holding beep_en at 1 does not extend or repeat the alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_1us | input | 1 | 1 MHz enable tick |
| rate_50hz | input | 1 | 1 selects 50 Hz frames, 0 selects 60 Hz |
| beep_en | input | 1 | Alarm request; its rising edge arms a beep |
| hsync | output | 1 | Horizontal sync pulse |
| vsync | output | 1 | Vertical sync pulse |
| beep_out | output | 1 | Audio alarm level |

## Verification
The assertions check two things on every cycle. First, neither sync output moves without a tick. Second, the alarm starts and stops only on a rising vertical sync edge. Pulse widths, line and frame lengths, the deferred rate change, the exact alarm length, the restart on a second request and the edge-only request rule are counted in cycles by the bench's directed scenarios. The bench also checks all of these against a cycle model during a random phase with irregular ticks, rate flips and request toggles.

// File: rtl/dsb_pkg.sv
package dsb_pkg;

    typedef enum logic {
        RATE_60HZ = 1'b0,
        RATE_50HZ = 1'b1
    } rate_e;

    localparam int unsigned DEF_LINE_TICKS  = 63;
    localparam int unsigned DEF_HS_TICKS    = 12;
    localparam int unsigned DEF_FRAME_50    = 20000;
    localparam int unsigned DEF_FRAME_60    = 16667;
    localparam int unsigned DEF_VS_TICKS    = 192;
    localparam int unsigned DEF_BEEP_FRAMES = 15;

    localparam int unsigned BEEP_W = 8;

    typedef struct packed {
        logic              pending;
        logic [BEEP_W-1:0] left;
    } beep_state_t;

    function automatic int unsigned width_for(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic int unsigned max_of(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dsb_line_timer.sv
module dsb_line_timer
    import dsb_pkg::*;
#(
    parameter int unsigned TICKS = DEF_LINE_TICKS,
    parameter int unsigned HIGH  = DEF_HS_TICKS
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic pulse
);
    localparam int unsigned W = width_for(TICKS);
    localparam logic [W-1:0] LAST = W'(TICKS - 1);
    localparam logic [W-1:0] HI   = W'(HIGH);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign pulse = (cnt < HI);
endmodule

// File: rtl/dsb_frame_timer.sv
module dsb_frame_timer
    import dsb_pkg::*;
#(
    parameter int unsigned T50  = DEF_FRAME_50,
    parameter int unsigned T60  = DEF_FRAME_60,
    parameter int unsigned HIGH = DEF_VS_TICKS
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic rate_sel,
    output logic pulse,
    output logic wrap
);
    localparam int unsigned W = width_for(max_of(T50, T60));
    localparam logic [W-1:0] LAST50 = W'(T50 - 1);
    localparam logic [W-1:0] LAST60 = W'(T60 - 1);
    localparam logic [W-1:0] HI     = W'(HIGH);

    logic [W-1:0] cnt;
    rate_e        rate_q;
    logic [W-1:0] last;

    assign last = (rate_q == RATE_50HZ) ? LAST50 : LAST60;
    assign wrap = tick && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            rate_q <= rate_e'(rate_sel);
        end else if (tick) begin
            if (cnt == last) begin
                cnt    <= '0;
                rate_q <= rate_e'(rate_sel);
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign pulse = (cnt < HI);
endmodule

// File: rtl/dsb_beep_timer.sv
module dsb_beep_timer
    import dsb_pkg::*;
#(
    parameter int unsigned FRAMES = DEF_BEEP_FRAMES
) (
    input  logic clk,
    input  logic rst,
    input  logic beep_en,
    input  logic frame_wrap,
    output logic beep
);
    localparam logic [BEEP_W-1:0] LOAD = BEEP_W'(FRAMES);

    beep_state_t st;
    logic        en_q;
    logic        req;

    assign req = beep_en & ~en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= '0;
            en_q <= 1'b0;
        end else begin
            en_q <= beep_en;
            if (frame_wrap && (st.pending || req)) begin
                st.left    <= LOAD;
                st.pending <= 1'b0;
            end else if (frame_wrap) begin
                if (st.left != '0) st.left <= st.left - 1'b1;
            end else if (req) begin
                st.pending <= 1'b1;
            end
        end
    end

    assign beep = (st.left != '0);
endmodule

// File: rtl/disp_sync_beep.sv
module disp_sync_beep
    import dsb_pkg::*;
#(
    parameter int unsigned LINE_TICKS  = DEF_LINE_TICKS,
    parameter int unsigned HS_TICKS    = DEF_HS_TICKS,
    parameter int unsigned FRAME_50    = DEF_FRAME_50,
    parameter int unsigned FRAME_60    = DEF_FRAME_60,
    parameter int unsigned VS_TICKS    = DEF_VS_TICKS,
    parameter int unsigned BEEP_FRAMES = DEF_BEEP_FRAMES
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_1us,
    input  logic rate_50hz,
    input  logic beep_en,
    output logic hsync,
    output logic vsync,
    output logic beep_out
);
    logic frame_wrap;

    dsb_line_timer #(.TICKS(LINE_TICKS), .HIGH(HS_TICKS)) line_i (
        .clk(clk), .rst(rst), .tick(tick_1us), .pulse(hsync)
    );

    dsb_frame_timer #(.T50(FRAME_50), .T60(FRAME_60), .HIGH(VS_TICKS)) frame_i (
        .clk(clk), .rst(rst), .tick(tick_1us), .rate_sel(rate_50hz),
        .pulse(vsync), .wrap(frame_wrap)
    );

    dsb_beep_timer #(.FRAMES(BEEP_FRAMES)) beep_i (
        .clk(clk), .rst(rst), .beep_en(beep_en), .frame_wrap(frame_wrap),
        .beep(beep_out)
    );
endmodule

// File: rtl/disp_sync_beep_chk.sv
module disp_sync_beep_chk (
    input logic clk,
    input logic rst,
    input logic tick_1us,
    input logic hsync,
    input logic vsync,
    input logic beep_out
);
    assert_hs_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !tick_1us |=> $stable(hsync));

    assert_vs_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !tick_1us |=> $stable(vsync));

    assert_beep_start_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(beep_out) |-> $rose(vsync));

    assert_beep_stop_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(beep_out) |-> $rose(vsync));
endmodule

bind disp_sync_beep disp_sync_beep_chk chk_i (
    .clk(clk), .rst(rst), .tick_1us(tick_1us),
    .hsync(hsync), .vsync(vsync), .beep_out(beep_out)
);

// File: tb/disp_sync_beep_tb_top.sv
module disp_sync_beep_tb_top;
    localparam int L  = 63;
    localparam int HS = 12;
    localparam int F5 = 200;
    localparam int F6 = 167;
    localparam int VS = 19;
    localparam int B  = 3;

    logic clk = 0, rst = 1, tick = 0, rate = 1, en = 0;
    logic hs, vs, bp;
    int checks = 0, errors = 0;
    bit cmp_on = 0;

    always #5 clk = ~clk;

    disp_sync_beep #(.LINE_TICKS(L), .HS_TICKS(HS), .FRAME_50(F5), .FRAME_60(F6),
                     .VS_TICKS(VS), .BEEP_FRAMES(B)) dut_i (
        .clk(clk), .rst(rst), .tick_1us(tick), .rate_50hz(rate), .beep_en(en),
        .hsync(hs), .vsync(vs), .beep_out(bp)
    );

    function automatic int frame_len(bit r);
        return r ? F5 : F6;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // cycle model built from the requirements
    int m_lc, m_fc, m_rem; bit m_rq, m_pend, m_enq;
    always @(posedge clk) begin
        bit rise, wrap;
        if (rst) begin
            m_lc = 0; m_fc = 0; m_rq = rate; m_pend = 0; m_rem = 0; m_enq = 0;
        end else begin
            rise = en && !m_enq;
            m_enq = en;
            wrap = tick && (m_fc == frame_len(m_rq) - 1);
            if (tick) begin
                m_lc = (m_lc == L - 1) ? 0 : m_lc + 1;
                m_fc = wrap ? 0 : m_fc + 1;
                if (wrap) m_rq = rate;
            end
            if (wrap && (m_pend || rise)) begin m_rem = B; m_pend = 0; end
            else if (wrap) begin if (m_rem != 0) m_rem--; end
            else if (rise) m_pend = 1;
        end
    end

    always @(negedge clk) if (cmp_on && !rst) begin
        chk("R3 hsync model", hs, m_lc < HS);
        chk("R4 vsync model", vs, m_fc < VS);
        chk("R7 beep model",  bp, m_rem != 0);
    end

    task automatic wait_rise_vs();
        bit p = vs;
        forever begin @(negedge clk); if (vs && !p) break; p = vs; end
    endtask

    task automatic pulse_en();
        en = 1; @(negedge clk); en = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n, hi, lo;
        bit p;
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        chk("R1 hsync in reset", hs, 1); chk("R1 vsync in reset", vs, 1);
        chk("R1 beep in reset", bp, 0);
        rst = 0; @(negedge clk);
        chk("R1 hsync after reset", hs, 1); chk("R1 beep after reset", bp, 0);
        cmp_on = 1;
        // R2: no tick holds hsync
        repeat (20) begin @(negedge clk); chk("R2 hsync hold", hs, 1); end
        tick = 1;
        // R3 widths
        p = hs; n = 0;
        while (!(hs && !p)) begin p = hs; @(negedge clk); end
        hi = 0; lo = 0;
        for (int i = 0; i < L; i++) begin if (hs) hi++; else lo++; @(negedge clk); end
        chk("R3 hsync high ticks", hi, HS); chk("R3 hsync low ticks", lo, L - HS);
        // R6 idle
        n = 0;
        for (int i = 0; i < 1000; i++) begin @(negedge clk); n += bp; end
        chk("R6 no beep without request", n, 0);
        // R4/R5 rate change at boundary
        wait_rise_vs();
        repeat (50) @(negedge clk);
        rate = 0;
        n = 50; p = vs;
        forever begin @(negedge clk); n++; if (vs && !p) break; p = vs; end
        chk("R5 frame keeps old length", n, frame_len(1));
        n = 0; p = vs;
        forever begin @(negedge clk); n++; if (vs && !p) break; p = vs; end
        chk("R4 60 Hz frame length", n, frame_len(0));
        rate = 1; wait_rise_vs(); wait_rise_vs();
        // R7 pulse request
        repeat (30) @(negedge clk);
        pulse_en();
        n = 0;
        for (int i = 0; i < 6 * F5; i++) begin @(negedge clk); n += bp; end
        chk("R7 beep length", n, B * F5);
        // R9 held request
        en = 1; n = 0;
        for (int i = 0; i < 8 * F5; i++) begin @(negedge clk); n += bp; end
        chk("R9 held enable single beep", n, B * F5);
        en = 0; @(negedge clk);
        // R8 restart
        wait_rise_vs(); repeat (30) @(negedge clk);
        pulse_en(); n = 0;
        while (!bp) @(negedge clk);
        for (int i = 0; i < F5 + 50; i++) begin n += bp; @(negedge clk); end
        pulse_en(); n++;
        for (int i = 0; i < 8 * F5; i++) begin n += bp; @(negedge clk); end
        chk("R8 restart length", n, (B + 2) * F5);
        // random phase
        for (int i = 0; i < 40000; i++) begin
            tick = ($urandom % 8) != 0;
            if (($urandom % 3000) == 0) rate = ~rate;
            if (($urandom % 400) == 0) en = ~en;
            @(negedge clk);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule